// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Coalescing Registers

This block is the software-visible register file of a single DMA channel, plus the logic that decides when the channel interrupts. A 32-bit register port gives read and write access to a control word, a status word, a current descriptor pointer and a tail descriptor pointer. The separate data engine reports two events as single-cycle pulses: a finished packet and the point where it has run out of descriptors. The block returns a run level, halted and idle levels, a kick pulse that tells the engine to start on new descriptors, and one interrupt line.

Interrupts are coalesced in two ways. A packet counter counts down from a programmable threshold and raises a completion event when it reaches zero. A delay timer restarts on each finished packet and raises a delay event if no further packet arrives before it runs out. Both live values can be read back through the status word. The channel mode is held in a three-state machine. `ST_HALTED` is entered at reset and on a soft reset. `ST_BUSY` is entered from `ST_HALTED` by a control write with run set, and from `ST_IDLE` by a tail pointer write or a run write. `ST_IDLE` is entered from `ST_BUSY` on an idle-set pulse. A soft reset moves any state back to `ST_HALTED`.

The register port decodes word offsets within one channel's 0x30-byte window: control at 0x00, status at 0x04, current descriptor at 0x08, tail descriptor at 0x10. Address bits 1:0 are ignored and other offsets read as zero. A second channel is a second instance placed at 0x30.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, control reads 0x00010000 and status reads 0x00010001 (halted, counter 1, timer 0). The outputs are halted=1, run=0, idle=0, irq=0.
- R2: A control write stores the written word with bit 1 forced to 1, and the run output follows control bit 0.
- R3: A control write with bit 0 set moves `ST_HALTED` or `ST_IDLE` to `ST_BUSY`, clearing halted and idle. An idle-set pulse moves `ST_BUSY` to `ST_IDLE` and has no effect in `ST_HALTED`.
- R4: A control write with bit 2 set, or any control write while bit 2 is still pending, is a soft reset. It puts the state in `ST_HALTED`, clears status bits 14:12, stops the timer and sets control to 0x00010004. The first control read returns bit 2 set and clears it, so the next read returns 0x00010000. A run write made while bit 2 is pending leaves the channel halted.
- R5: The packet counter reloads from control bits 23:16 on every control write and decrements on each packet-done pulse. The pulse that would bring it to zero sets status bit 12 and reloads it. A threshold of 0 counts 256 packets.
- R6: When control bits 31:24 (D) are nonzero, each packet-done pulse restarts the timer at D and restarts its prescaler. The timer counts down once every TICK_DIV cycles. D*TICK_DIV clock edges after the pulse it expires, which sets status bit 13 and reloads the packet counter.
- R7: A status read returns the timer in bits 31:24, the low 8 bits of the counter in 23:16, the event bits in 14:12, idle in bit 1 and halted in bit 0.
- R8: Writing 1 to any of status bits 14:12 clears that event bit. All other status write bits are ignored. An event arriving in the same cycle as its clear stays set.
- R9: irq is high exactly when some status bit in 14:12 and the control bit at the same position are both 1.
- R10: A tail pointer write stores the value and clears idle. The kick output is high for the one cycle after the write. Both pointer registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears a pending soft-reset bit on a control read) |
| reg_addr | input | ADDR_W | Byte offset within the channel window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| pkt_done | input | 1 | One-cycle pulse per finished packet |
| idle_set | input | 1 | One-cycle pulse when the engine runs out of descriptors |
| run | output | 1 | Control run bit |
| halted | output | 1 | Channel is halted |
| idle | output | 1 | Channel is idle |
| kick | output | 1 | One-cycle pulse after a tail pointer write |
| irq | output | 1 | Masked interrupt line |

## Verification
The assertions assume that packet-done and idle-set are single-cycle pulses. They also assume that a register write and a read of the control word never happen in the same cycle. The stimulus drives every strobe for exactly one clock, from the falling edge. It never overlaps a register access with an engine pulse. It never lets a packet pulse land on the cycle of a timer expiry, so the priority between those two events is not exercised.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    typedef enum logic [1:0] {
        ST_HALTED = 2'd0,
        ST_BUSY   = 2'd1,
        ST_IDLE   = 2'd2
    } chan_state_e;

    // word indices within the channel window
    localparam logic [3:0] WI_CTRL = 4'd0;
    localparam logic [3:0] WI_STAT = 4'd1;
    localparam logic [3:0] WI_CUR  = 4'd2;
    localparam logic [3:0] WI_TAIL = 4'd4;

    localparam logic [31:0] CTRL_POR   = 32'h0001_0000;
    localparam logic [31:0] CTRL_SRST  = 32'h0001_0004;
    localparam int          B_RUN      = 0;
    localparam int          B_TAILMODE = 1;
    localparam int          B_SRST     = 2;
endpackage

// File: rtl/chan_run_fsm.sv
module chan_run_fsm
    import dma_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic run_go,
    input  logic tail_wr,
    input  logic idle_set,
    output logic halted,
    output logic idle,
    output logic kick
);
    chan_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALTED: if (run_go) state_d = ST_BUSY;
            ST_BUSY:   if (idle_set) state_d = ST_IDLE;
            ST_IDLE:   if (tail_wr || run_go) state_d = ST_BUSY;
            default:   state_d = ST_HALTED;
        endcase
        if (soft_rst) state_d = ST_HALTED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALTED;
            kick    <= 1'b0;
        end else begin
            state_q <= state_d;
            kick    <= tail_wr;
        end
    end

    always_comb begin
        halted = (state_q == ST_HALTED);
        idle   = (state_q == ST_IDLE);
    end

    // R4: a soft reset always lands in the halted state
    assert_srst_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> halted);
    // R3: an idle pulse while halted changes nothing
    assert_idle_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && idle_set && !run_go) |=> (halted && !idle));
    // R10: kick follows a tail write by one cycle
    assert_kick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tail_wr |=> kick);
endmodule

// File: rtl/chan_coalesce.sv
module chan_coalesce #(
    parameter int TICK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reload,
    input  logic [7:0] new_thr,
    input  logic [7:0] cur_thr,
    input  logic       soft_rst,
    input  logic       pkt_done,
    input  logic [7:0] delay,
    output logic [7:0] cnt_rd,
    output logic [7:0] tmr_rd,
    output logic       ioc_evt,
    output logic       dly_evt
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [8:0]       cnt_q;
    logic [7:0]       tmr_q;
    logic [PRE_W-1:0] pre_q;
    logic             tick, load_tmr;

    function automatic logic [8:0] expand(input logic [7:0] t);
        return (t == 8'd0) ? 9'd256 : {1'b0, t};
    endfunction

    assign tick     = (tmr_q != 8'd0) && (pre_q == PRE_LAST);
    assign load_tmr = pkt_done && (delay != 8'd0) && !soft_rst;
    assign ioc_evt  = pkt_done && (cnt_q == 9'd1) && !reload;
    assign dly_evt  = tick && (tmr_q == 8'd1) && !load_tmr && !soft_rst;
    assign cnt_rd   = cnt_q[7:0];
    assign tmr_rd   = tmr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= 9'd1;
            tmr_q <= 8'd0;
            pre_q <= '0;
        end else begin
            if (reload)
                cnt_q <= expand(new_thr);
            else if (pkt_done)
                cnt_q <= ioc_evt ? expand(cur_thr) : cnt_q - 9'd1;
            else if (dly_evt)
                cnt_q <= expand(cur_thr);

            if (soft_rst)
                tmr_q <= 8'd0;
            else if (load_tmr)
                tmr_q <= delay;
            else if (tick)
                tmr_q <= tmr_q - 8'd1;

            if (soft_rst || load_tmr || tmr_q == 8'd0 || tick)
                pre_q <= '0;
            else
                pre_q <= pre_q + 1'b1;
        end
    end

    // R5: the counter never sits at zero
    assert_cnt_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != 9'd0);
    // R6: a packet with a nonzero delay restarts the timer at that delay
    assert_tmr_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_tmr |=> (tmr_q == $past(delay)));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              pkt_done,
    input  logic              idle_set,
    output logic              run,
    output logic              halted,
    output logic              idle,
    output logic              kick,
    output logic              irq
);
    localparam int WI_W = ADDR_W - 2;

    logic [WI_W-1:0] wi;
    logic [31:0] ctrl_q, ctrl_nxt, cur_q, tail_q;
    logic [2:0]  evt_q, evt_set;
    logic        wr_ctrl, wr_stat, wr_tail, rd_ctrl;
    logic        soft_rst, run_go;
    logic [7:0]  cnt_rd, tmr_rd;
    logic        ioc_evt, dly_evt;

    assign wi      = reg_addr[ADDR_W-1:2];
    assign wr_ctrl = reg_wr && (wi == WI_W'(WI_CTRL));
    assign wr_stat = reg_wr && (wi == WI_W'(WI_STAT));
    assign wr_tail = reg_wr && (wi == WI_W'(WI_TAIL));
    assign rd_ctrl = reg_rd && (wi == WI_W'(WI_CTRL));

    always_comb begin
        ctrl_nxt = reg_wdata;
        ctrl_nxt[B_TAILMODE] = 1'b1;
        ctrl_nxt[B_SRST]     = reg_wdata[B_SRST] | ctrl_q[B_SRST];
        soft_rst = wr_ctrl && ctrl_nxt[B_SRST];
        if (ctrl_nxt[B_SRST]) ctrl_nxt = CTRL_SRST;
        run_go   = wr_ctrl && !soft_rst && reg_wdata[B_RUN];
    end

    assign evt_set = {1'b0, dly_evt, ioc_evt};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_POR;
            evt_q  <= 3'b000;
            cur_q  <= 32'd0;
            tail_q <= 32'd0;
        end else begin
            if (wr_ctrl)      ctrl_q <= ctrl_nxt;
            else if (rd_ctrl) ctrl_q[B_SRST] <= 1'b0;

            if (soft_rst)     evt_q <= 3'b000;
            else              evt_q <= (evt_q & ~(wr_stat ? reg_wdata[14:12] : 3'b000)) | evt_set;

            if (reg_wr && wi == WI_W'(WI_CUR)) cur_q <= reg_wdata;
            if (wr_tail)                       tail_q <= reg_wdata;
        end
    end

    chan_coalesce #(.TICK_DIV(TICK_DIV)) coal_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (wr_ctrl),
        .new_thr  (ctrl_nxt[23:16]),
        .cur_thr  (ctrl_q[23:16]),
        .soft_rst (soft_rst),
        .pkt_done (pkt_done),
        .delay    (ctrl_q[31:24]),
        .cnt_rd   (cnt_rd),
        .tmr_rd   (tmr_rd),
        .ioc_evt  (ioc_evt),
        .dly_evt  (dly_evt)
    );

    chan_run_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .run_go   (run_go),
        .tail_wr  (wr_tail),
        .idle_set (idle_set),
        .halted   (halted),
        .idle     (idle),
        .kick     (kick)
    );

    always_comb begin
        unique case (wi)
            WI_W'(WI_CTRL): reg_rdata = ctrl_q;
            WI_W'(WI_STAT): reg_rdata = {tmr_rd, cnt_rd, 1'b0, evt_q, 10'd0, idle, halted};
            WI_W'(WI_CUR):  reg_rdata = cur_q;
            WI_W'(WI_TAIL): reg_rdata = tail_q;
            default:        reg_rdata = 32'd0;
        endcase
    end

    assign run = ctrl_q[B_RUN];
    assign irq = |(evt_q & ctrl_q[14:12]);

    // R6: a timer expiry is latched in status bit 13
    assert_dly_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_evt && !soft_rst) |=> evt_q[1]);
    // R4: after a soft reset the pending bit is visible in control
    assert_srst_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ctrl_q[B_SRST]);
endmodule

// File: tb/dma_chan_regs_tb_top.sv
module dma_chan_regs_tb_top;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pkt_done = 1'b0, idle_set = 1'b0;
    logic        run, halted, idle, kick, irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dma_chan_regs #(.ADDR_W(6), .TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pkt_done(pkt_done), .idle_set(idle_set), .run(run), .halted(halted),
        .idle(idle), .kick(kick), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #2 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pkt();
        pkt_done = 1'b1; @(negedge clk); pkt_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 outputs", {28'd0, halted, run, idle, irq}, 32'h8);
        rd(6'h00, v); chk("R1 ctrl", v, 32'h0001_0000);
        rd(6'h04, v); chk("R1 status", v, 32'h0001_0001);
    endtask

    task automatic t_run();
        logic [31:0] v;
        wr(6'h00, 32'h0001_1001);
        rd(6'h00, v); chk("R2 ctrl forced bit1", v, 32'h0001_1003);
        chk("R2 run out", {31'd0, run}, 32'd1);
        chk("R3 halted cleared", {30'd0, halted, idle}, 32'd0);
    endtask

    task automatic t_count3();
        logic [31:0] v;
        wr(6'h00, 32'h0003_1001);
        pkt(); pkt();
        rd(6'h04, v); chk("R5 R7 count 3 after two", v, 32'h0001_0000);
        chk("R9 no irq yet", {31'd0, irq}, 32'd0);
        pkt();
        chk("R9 irq on threshold", {31'd0, irq}, 32'd1);
        rd(6'h04, v); chk("R5 reload and bit12", v, 32'h0003_1000);
        wr(6'h04, 32'h0000_1003);
        rd(6'h04, v); chk("R8 w1c and ignored bits", v, 32'h0003_0000);
        chk("R8 irq dropped", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_count256();
        logic [31:0] v;
        wr(6'h00, 32'h0000_1001);
        rd(6'h04, v); chk("R5 threshold 0 reads 0", v[23:16], 32'h0);
        for (int i = 0; i < 255; i++) pkt();
        rd(6'h04, v); chk("R5 255 pulses", v, 32'h0001_0000);
        pkt();
        chk("R5 256th raises", {31'd0, irq}, 32'd1);
        wr(6'h04, 32'h0000_1000);
    endtask

    task automatic t_delay();
        logic [31:0] v;
        wr(6'h00, 32'h0502_2001);
        pkt();
        rd(6'h04, v); chk("R6 R7 timer loaded", v, 32'h0501_0000);
        repeat (5 * DIV - 2) @(negedge clk);
        chk("R6 not before deadline", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R6 expiry irq", {31'd0, irq}, 32'd1);
        rd(6'h04, v); chk("R6 bit13 and reload", v, 32'h0002_2000);
        wr(6'h04, 32'h0000_2000);
        // restart
        pkt();
        repeat (3 * DIV) @(negedge clk);
        pkt();
        chk("R9 masked bit12 no irq", {31'd0, irq}, 32'd0);
        repeat (5 * DIV - 1) @(negedge clk);
        chk("R6 restart delays expiry", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R6 restart expiry", {31'd0, irq}, 32'd1);
        rd(6'h04, v); chk("R7 both events", v, 32'h0002_3000);
        wr(6'h00, 32'h0002_0001);
        chk("R9 mask off", {31'd0, irq}, 32'd0);
        wr(6'h04, 32'h0000_7000);
    endtask

    task automatic t_ptr();
        logic [31:0] v;
        idle_set = 1'b1; @(negedge clk); idle_set = 1'b0;
        chk("R3 idle set", {30'd0, halted, idle}, 32'd1);
        wr(6'h10, 32'h0000_1040);
        chk("R10 kick", {31'd0, kick}, 32'd1);
        chk("R10 idle cleared", {31'd0, idle}, 32'd0);
        @(negedge clk);
        chk("R10 kick one cycle", {31'd0, kick}, 32'd0);
        wr(6'h08, 32'h0000_2000);
        rd(6'h10, v); chk("R10 tail readback", v, 32'h0000_1040);
        rd(6'h08, v); chk("R10 cur readback", v, 32'h0000_2000);
    endtask

    task automatic t_soft();
        logic [31:0] v;
        wr(6'h00, 32'h0000_0004);
        chk("R4 halted", {31'd0, halted}, 32'd1);
        wr(6'h00, 32'h0000_0001);
        chk("R4 run while pending", {31'd0, halted}, 32'd1);
        rd(6'h00, v); chk("R4 pending once", v, 32'h0001_0004);
        rd(6'h00, v); chk("R4 self clear", v, 32'h0001_0000);
        idle_set = 1'b1; @(negedge clk); idle_set = 1'b0;
        chk("R3 idle ignored halted", {30'd0, halted, idle}, 32'd2);
        wr(6'h00, 32'h0000_0001);
        chk("R3 run leaves halted", {31'd0, halted}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run();
        t_count3();
        t_count256();
        t_delay();
        t_ptr();
        t_soft();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule